// File: doc/BRIEF.md
# Presettable Synchronous Counter with Cascade Enables

This block is a small up-counter. It can be cleared, preloaded from a data word, or stepped by one on each clock edge. Stepping needs two enables. `en_p` only gates the stepping. `en_t` gates the stepping and also the carry output.

The carry output `carry_out` goes high when the count sits at its terminal value while `en_t` is high. Wiring one stage's `carry_out` into the next stage's `en_t` chains stages into a wider counter without any ripple in the clock.

The `DECADE` parameter selects the counting range:
- Binary counting (`DECADE = 0`) covers the full range of `WIDTH` bits, and the clear takes effect at the clock edge.
- Decade counting (`DECADE = 1`) stops at `DEC_MOD - 1`, and the clear takes effect at once, without waiting for the clock.

Top module: `cnt_pre`

## Requirements
- R1: In binary mode, `clr` high makes `q` equal to 0 after the next rising clock edge. It overrides `ld`, `en_p` and `en_t`.
- R2: In decade mode, `clr` high forces `q` to 0 at once, before any clock edge, and holds it there while `clr` stays high.
- R3: With `clr` low and `ld` high, the next rising edge copies `ld_val` into `q`, whatever the enables are.
- R4: With `clr` and `ld` low and both `en_p` and `en_t` high, `q` steps up by one at each rising edge.
- R5: With `clr` and `ld` low and either enable low, `q` keeps its value across the edge.
- R6: `carry_out` is high exactly when `en_t` is high and `q` equals the terminal value. The terminal value is 15 in binary mode and 9 in decade mode. `en_p` has no effect on `carry_out`.
- R7: In binary mode a step from 15 gives 0.
- R8: In decade mode a step from 9 gives 0.
- R9: In decade mode, a loaded value from 10 to 15 steps upward one at a time, and a step from 15 gives 0.
- R10: Two binary stages joined as a chain count as one 8-bit counter that wraps from 255 to 0. In the chain, the low stage's `carry_out` drives the high stage's `en_t`, and both stages share `en_p`, `ld` and `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Clear, active high: synchronous in binary mode, asynchronous in decade mode |
| ld | input | 1 | Preload request, active high |
| ld_val | input | WIDTH | Value copied into the count on a preload |
| en_p | input | 1 | Count enable that gates stepping only |
| en_t | input | 1 | Count enable that gates stepping and the carry output |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count indication, qualified by `en_t` |

## Verification
The bench builds three copies with `WIDTH = 4`:
- Two copies use `DECADE = 0` and are chained, so the 255-to-0 rollover of the 8-bit chain and the binary 15-to-0 wrap both come within reach.
- One copy uses `DECADE = 1` and `DEC_MOD = 10`. It exposes the clear that acts between clock edges and the 9-to-0 wrap.

Random preloads into the decade copy also land on the values 10 to 15. This drives the climb from those values through 15 and back to 0.

// File: rtl/cnt_pre_pkg.sv
package cnt_pre_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_HOLD  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_pre_ctl.sv
module cnt_pre_ctl
  import cnt_pre_pkg::*;
(
  input  logic    clk,
  input  logic    clr,
  input  logic    ld,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  // clear beats load, load beats stepping
  always_comb begin
    if (clr)              op = OP_CLEAR;
    else if (ld)          op = OP_LOAD;
    else if (en_p && en_t) op = OP_STEP;
    else                  op = OP_HOLD;
  end

  // R5: a single low enable never yields a step
  p_step_needs_both_r5: assert property (@(posedge clk)
    (op == OP_STEP) |-> (en_p && en_t && !ld && !clr));
endmodule

// File: rtl/cnt_pre_next.sv
module cnt_pre_next
  import cnt_pre_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] TERM = '1
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] inc;

  // out-of-range decade values fall through to the natural binary wrap
  assign inc = (q == TERM) ? '0 : q + 1'b1;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ld_val;
      OP_STEP:  nxt = inc;
      default:  nxt = q;
    endcase
  end
endmodule

// File: rtl/cnt_pre_reg.sv
module cnt_pre_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or posedge clr) begin
        if (clr) q <= '0;
        else     q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate

  // R1 / R2: a clear seen at an edge leaves zero behind it
  p_clear_zero_r1: assert property (@(posedge clk) clr |=> (q == '0));
endmodule

// File: rtl/cnt_pre_term.sv
module cnt_pre_term #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] TERM = '1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry_out
);
  assign carry_out = en_t && (q == TERM);

  // R6: carry never appears with the carry enable low
  p_carry_gated_r6: assert property (@(posedge clk) !en_t |-> !carry_out);
endmodule

// File: rtl/cnt_pre.sv
module cnt_pre
  import cnt_pre_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter bit DECADE  = 1'b0,
  parameter int DEC_MOD = 10
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam int               TERM_I = DECADE ? DEC_MOD - 1 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] TERM   = WIDTH'(TERM_I);

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;

  cnt_pre_ctl u_ctl (
    .clk  (clk),
    .clr  (clr),
    .ld   (ld),
    .en_p (en_p),
    .en_t (en_t),
    .op   (op)
  );

  cnt_pre_next #(.WIDTH(WIDTH), .TERM(TERM)) u_next (
    .op     (op),
    .q      (q),
    .ld_val (ld_val),
    .nxt    (nxt)
  );

  cnt_pre_reg #(.WIDTH(WIDTH), .ASYNC_CLR(DECADE)) u_reg (
    .clk (clk),
    .clr (clr),
    .nxt (nxt),
    .q   (q)
  );

  cnt_pre_term #(.WIDTH(WIDTH), .TERM(TERM)) u_term (
    .clk       (clk),
    .q         (q),
    .en_t      (en_t),
    .carry_out (carry_out)
  );

  // R3: preload lands on the next edge
  p_load_r3: assert property (@(posedge clk) disable iff (clr)
    ld |=> (q == $past(ld_val)));

  // R4: one step upward below the terminal value
  p_step_r4: assert property (@(posedge clk) disable iff (clr)
    (!ld && en_p && en_t && q != TERM) |=> (q == $past(q) + 1'b1));

  // R5: hold when either enable is low
  p_hold_r5: assert property (@(posedge clk) disable iff (clr)
    (!ld && !(en_p && en_t)) |=> $stable(q));

  // R7 / R8: terminal value rolls to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (clr)
    (!ld && en_p && en_t && q == TERM) |=> (q == '0));

  // R6: carry only at the terminal value
  p_carry_term_r6: assert property (@(posedge clk)
    carry_out |-> (q == TERM));
endmodule

// File: tb/test_cnt_pre.sv
`timescale 1ns/1ps
module test_cnt_pre;
  logic       clk = 1'b0;
  logic       clr = 1'b1, ld = 1'b0, ep = 1'b0, et = 1'b0;
  logic [3:0] d = '0;
  logic [3:0] q_lo, q_hi, q_dec;
  logic       c_lo, c_hi, c_dec;
  int n_chk = 0, n_bad = 0;
  int m_lo = 0, m_hi = 0, m_dec = 0;

  always #2.5 clk = ~clk;

  cnt_pre #(.WIDTH(4), .DECADE(1'b0)) i_cnt_pre (
    .clk(clk), .clr(clr), .ld(ld), .ld_val(d), .en_p(ep), .en_t(et),
    .q(q_lo), .carry_out(c_lo));

  cnt_pre #(.WIDTH(4), .DECADE(1'b0)) i_cnt_pre_hi (
    .clk(clk), .clr(clr), .ld(ld), .ld_val(d), .en_p(ep), .en_t(c_lo),
    .q(q_hi), .carry_out(c_hi));

  cnt_pre #(.WIDTH(4), .DECADE(1'b1), .DEC_MOD(10)) i_cnt_pre_dec (
    .clk(clk), .clr(clr), .ld(ld), .ld_val(d), .en_p(ep), .en_t(et),
    .q(q_dec), .carry_out(c_dec));

  function automatic int ref_next(int cur, bit c, bit l, int v, bit p, bit t, int term);
    if (c)           return 0;
    else if (l)      return v;
    else if (p && t) return (cur == term) ? 0 : (cur + 1) % 16;
    else             return cur;
  endfunction

  function automatic bit ref_carry(int cur, bit t, int term);
    return t && (cur == term);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // inputs already driven mid-cycle; check comb outputs, then clock
  task automatic step();
    int e_lo, e_hi, e_dec;
    bit cl;
    #0.5;
    cl = ref_carry(m_lo, et, 15);
    chk(c_lo == cl, "R6 low carry", c_lo, cl);
    chk(c_hi == ref_carry(m_hi, cl, 15), "R6 high carry", c_hi, ref_carry(m_hi, cl, 15));
    if (clr) begin
      m_dec = 0;
      chk(q_dec == 4'd0, "R2 clear before edge", q_dec, 0);
    end
    chk(c_dec == ref_carry(m_dec, et, 9), "R6 decade carry", c_dec, ref_carry(m_dec, et, 9));
    e_lo  = ref_next(m_lo, clr, ld, d, ep, et, 15);
    e_hi  = ref_next(m_hi, clr, ld, d, ep, cl, 15);
    e_dec = ref_next(m_dec, clr, ld, d, ep, et, 9);
    @(posedge clk);
    #1;
    m_lo = e_lo; m_hi = e_hi; m_dec = e_dec;
    chk(q_lo == 4'(m_lo), "R1/R3/R4/R5/R7 low stage", q_lo, m_lo);
    chk(q_hi == 4'(m_hi), "R10 high stage", q_hi, m_hi);
    chk(q_dec == 4'(m_dec), "R8/R9 decade", q_dec, m_dec);
  endtask

  task automatic drive(bit c, bit l, int v, bit p, bit t);
    clr = c; ld = l; d = 4'(v); ep = p; et = t;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    #1;
    // R1: reset state, clear wins over load and enables
    drive(1, 1, 7, 1, 1); step();
    chk(q_lo == 0 && q_dec == 0, "R1 clear overrides load", q_lo, 0);
    // R3: load with enables low
    drive(0, 1, 13, 0, 0); step();
    chk(q_lo == 13, "R3 load", q_lo, 13);
    // R5: hold with one enable low
    drive(0, 0, 0, 1, 0); step();
    drive(0, 0, 0, 0, 1); step();
    chk(q_lo == 13, "R5 hold", q_lo, 13);
    // R4, R7: step through 15 to 0
    drive(0, 0, 0, 1, 1);
    repeat (3) step();
    chk(q_lo == 0, "R7 binary wrap", q_lo, 0);
    // R9: decade loaded above range
    drive(0, 1, 12, 0, 0); step();
    drive(0, 0, 0, 1, 1);
    repeat (4) step();
    chk(q_dec == 0, "R9 decade 15 to 0", q_dec, 0);
    // R8: decade 9 to 0
    drive(0, 1, 8, 0, 0); step();
    drive(0, 0, 0, 1, 1); step();
    chk(c_dec == 1'b1, "R6 carry at 9", c_dec, 1);
    step();
    chk(q_dec == 0, "R8 decade wrap", q_dec, 0);
    // R10: 8-bit cascade from zero
    drive(1, 0, 0, 1, 1); step();
    drive(0, 0, 0, 1, 1);
    for (int k = 1; k <= 300; k++) begin
      step();
      chk({q_hi, q_lo} == 8'(k), "R10 cascade count", {q_hi, q_lo}, k % 256);
    end
    // random mix
    for (int k = 0; k < 2000; k++) begin
      drive(($urandom % 20) == 0, ($urandom % 10) == 0, $urandom % 16,
            ($urandom % 5) != 0, ($urandom % 5) != 0);
      step();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule